// File: doc/BRIEF.md
# Testable AND-EXOR Logic Network

This block is a two-level AND-EXOR network whose function is fixed at elaboration by two mask parameters. Each product term lists the inputs it uses in true form and the inputs it uses in complemented form. Every input that appears complemented anywhere is routed through one XOR gate shared with control `c1`. With `c1` high these gates invert, so the network computes the intended expression. With `c1` low all literals are in true form. The products are combined with control `c2` in a linear XOR cascade to give `f`. In normal use `c2` carries the constant term of the expression.

Two observation outputs let a short, function-independent test sequence reach every single stuck-at fault:

- `o1` is a linear XOR cascade over the outputs of the complementing gates. Its seed is `c1` when the number of complementing gates is even and 0 when that number is odd, so a fault on `c1` always causes an odd number of changes.
- `o2` is the AND of those inputs that never pass through a complementing gate and appear in an even number of product terms. A fault on such an input could not otherwise reach `f`.

The sequence has n+6 vectors. Six are fixed vectors that drive all-zero or all-one data under chosen control values. The other n are walking-zero vectors.

The default configuration has n=5 and four terms:

`f = c2 ^ x0&~x1&x4 ^ x1&x2&x3 ^ ~x1&x3&x4 ^ x0&x2&x4`

Top module: `esop_selftest_net`

## Requirements
- R1: Mask encoding: bit `t*N+j` of `POS_MASK` (`NEG_MASK`) set means term t uses input j in true (complemented) form. With `c1`=1, `f` = `c2` XOR, over all terms, the AND of each term's literals. For the default masks this equals the expression above for every input combination.
- R2: With `c1`=0 every literal is in true form: `f` = `c2` XOR the AND over each term of all inputs it uses. For the default masks: `c2 ^ x0&x1&x4 ^ x1&x2&x3 ^ x1&x3&x4 ^ x0&x2&x4`.
- R3: With `x` and `c1` held, inverting `c2` always inverts `f`.
- R4: `o1` equals the XOR of the inputs that pass through a complementing gate, XORed with `c1` (the parity-fix seed makes this hold for either gate count). For the default masks `o1` = `x[1]` XOR `c1`.
- R5: `o2` is the AND of the inputs that never pass through a complementing gate and appear in a nonzero even number of terms, and is 0 if there are none. For the default masks `o2` = `x[0] & x[2] & x[3]`.
- R6: The test sequence gives the responses R1 to R5 predict. As (`c1`,`c2`,`x`), its six fixed vectors are (0,0,00000), (0,1,11111), (0,1,00000), (0,0,11111), (1,0,00000) and (1,0,11111). It then has n walking-zero vectors with `c1`=`c2`=0 and exactly one `x` bit low.
- R7: For every single stuck-at-0 or stuck-at-1 on any bit of `x`, on `c1` or on `c2`, at least one vector of the R6 sequence gives an (`f`,`o1`,`o2`) triple that differs from the fault-free triple.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | Primary data inputs |
| c1 | input | 1 | Complement enable for complemented literals; 1 in normal use |
| c2 | input | 1 | Seed of the output cascade; constant term in normal use |
| f | output | 1 | Function output |
| o1 | output | 1 | Check-cascade observation output |
| o2 | output | 1 | Observation AND over even-use true-form inputs |

## Verification
The literal inversion driven by `c1` and the constant seed driven by `c2` both act on `f`, and they can change in the same vector. The bench provokes this with vectors that flip both controls together: the exhaustive and random passes, and the fixed test vectors that move `c1` and `c2` between neighbours. Each response is judged against a bench model that applies both effects independently. A third pass presents each injected input or control fault along the whole test sequence and judges detection from the three outputs alone.

// File: rtl/esop_literal_stage.sv
module esop_literal_stage #(
    parameter int          N    = 5,
    parameter logic [N-1:0] MASK = '0
) (
    input  logic [N-1:0] x,
    input  logic         c1,
    output logic [N-1:0] lit
);
    for (genvar j = 0; j < N; j++) begin : g_lit
        assign lit[j] = x[j] ^ (c1 & MASK[j]);
    end
endmodule

// File: rtl/esop_and_stage.sv
module esop_and_stage #(
    parameter int              N        = 5,
    parameter int              T        = 4,
    parameter logic [N*T-1:0]  POS_MASK = '0,
    parameter logic [N*T-1:0]  NEG_MASK = '0
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] lit,
    output logic [T-1:0] prod
);
    for (genvar t = 0; t < T; t++) begin : g_term
        logic [N-1:0] term_in;
        for (genvar j = 0; j < N; j++) begin : g_in
            // unused positions contribute a 1 to the product
            assign term_in[j] = (x[j]   | ~POS_MASK[t*N+j]) &
                                (lit[j] | ~NEG_MASK[t*N+j]);
        end
        assign prod[t] = &term_in;
    end
endmodule

// File: rtl/esop_xor_chain.sv
module esop_xor_chain #(
    parameter int           W   = 4,
    parameter logic [W-1:0] USE = '1
) (
    input  logic         seed,
    input  logic [W-1:0] v,
    output logic         y
);
    // linear cascade: one XOR per used position, seed at the head
    always_comb begin
        logic acc;
        acc = seed;
        for (int i = 0; i < W; i++) begin
            acc = acc ^ (v[i] & USE[i]);
        end
        y = acc;
    end
endmodule

// File: rtl/esop_obs_and.sv
module esop_obs_and #(
    parameter int           N    = 5,
    parameter logic [N-1:0] MASK = '0
) (
    input  logic [N-1:0] x,
    output logic         y
);
    assign y = (|MASK) & (&(x | ~MASK));
endmodule

// File: rtl/esop_selftest_net.sv
module esop_selftest_net #(
    parameter int             N        = 5,
    parameter int             T        = 4,
    parameter logic [N*T-1:0] POS_MASK = 20'b10101_11000_01110_10001,
    parameter logic [N*T-1:0] NEG_MASK = 20'b00000_00010_00000_00010
) (
    input  logic [N-1:0] x,
    input  logic         c1,
    input  logic         c2,
    output logic         f,
    output logic         o1,
    output logic         o2
);
    function automatic logic [N-1:0] neg_inputs(input logic [N*T-1:0] m);
        logic [N-1:0] r;
        r = '0;
        for (int t = 0; t < T; t++) r = r | m[t*N +: N];
        return r;
    endfunction

    function automatic int ones(input logic [N-1:0] v);
        int c;
        c = 0;
        for (int j = 0; j < N; j++) c = c + int'(v[j]);
        return c;
    endfunction

    function automatic logic [N-1:0] even_true_inputs(input logic [N*T-1:0] p,
                                                      input logic [N*T-1:0] n);
        logic [N-1:0] r;
        logic [N-1:0] ng;
        int           c;
        ng = neg_inputs(n);
        r  = '0;
        for (int j = 0; j < N; j++) begin
            c = 0;
            for (int t = 0; t < T; t++) c = c + int'(p[t*N+j]);
            r[j] = !ng[j] && (c > 0) && (c % 2 == 0);
        end
        return r;
    endfunction

    localparam logic [N-1:0] LIT_MASK  = neg_inputs(NEG_MASK);
    localparam int           LIT_COUNT = ones(LIT_MASK);
    localparam logic         PAR_FIX   = (LIT_COUNT % 2 == 0);
    localparam logic [N-1:0] O2_MASK   = even_true_inputs(POS_MASK, NEG_MASK);

    logic [N-1:0] lit_vec;
    logic [T-1:0] prod_vec;
    logic         chk_seed;

    esop_literal_stage #(.N(N), .MASK(LIT_MASK)) u_lit (
        .x(x), .c1(c1), .lit(lit_vec)
    );

    esop_and_stage #(.N(N), .T(T), .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK)) u_and (
        .x(x), .lit(lit_vec), .prod(prod_vec)
    );

    esop_xor_chain #(.W(T), .USE({T{1'b1}})) u_lin (
        .seed(c2), .v(prod_vec), .y(f)
    );

    // parity-fix gate: present only for an even number of complementing gates
    assign chk_seed = c1 & PAR_FIX;

    esop_xor_chain #(.W(N), .USE(LIT_MASK)) u_chk (
        .seed(chk_seed), .v(lit_vec), .y(o1)
    );

    esop_obs_and #(.N(N), .MASK(O2_MASK)) u_obs (
        .x(x), .y(o2)
    );

    always_comb begin
        assert_o1_parity_R4: assert (o1 == ((^(x & LIT_MASK)) ^ c1))
            else $error("o1 parity mismatch");
        assert_o2_inputs_R5: assert (!o2 || ((x & O2_MASK) == O2_MASK))
            else $error("o2 high with a selected input low");
        if (!c1) begin
            assert_true_lits_R2: assert (lit_vec == x)
                else $error("literal stage not transparent with c1 low");
        end
        if (!c1 && x == '0) begin
            assert_zero_data_R2: assert (f == c2)
                else $error("f differs from c2 with zero data");
        end
        if (!c1 && x == '1) begin
            assert_ones_data_R3: assert (f == (c2 ^ T[0]))
                else $error("f differs from c2 xor term parity with all-one data");
        end
    end
endmodule

// File: tb/esop_selftest_net_bench.sv
module esop_selftest_net_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 5;
    localparam int NV = N + 6;

    logic         clk = 1'b0;
    logic [N-1:0] x   = '0;
    logic         c1  = 1'b0;
    logic         c2  = 1'b0;
    logic         f, o1, o2;
    int           errors = 0;
    int           checks = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    esop_selftest_net u_esop_selftest_net (
        .x(x), .c1(c1), .c2(c2), .f(f), .o1(o1), .o2(o2)
    );

    function automatic logic [2:0] model(input logic a1, input logic a2, input logic [N-1:0] v);
        logic nx1, rf;
        nx1 = v[1] ^ a1;
        rf  = a2 ^ (v[0] & nx1 & v[4]) ^ (v[1] & v[2] & v[3]) ^
              (nx1 & v[3] & v[4]) ^ (v[0] & v[2] & v[4]);
        return {rf, v[1] ^ a1, v[0] & v[2] & v[3]};
    endfunction

    task automatic test_vec(input int k, output logic a1, output logic a2, output logic [N-1:0] v);
        case (k)
            0: begin a1 = 0; a2 = 0; v = '0; end
            1: begin a1 = 0; a2 = 1; v = '1; end
            2: begin a1 = 0; a2 = 1; v = '0; end
            3: begin a1 = 0; a2 = 0; v = '1; end
            4: begin a1 = 1; a2 = 0; v = '0; end
            5: begin a1 = 1; a2 = 0; v = '1; end
            default: begin a1 = 0; a2 = 0; v = ~(N'(1) << (k - 6)); end
        endcase
    endtask

    task automatic drive(input logic a1, input logic a2, input logic [N-1:0] v);
        @(posedge clk);
        c1 = a1; c2 = a2; x = v;
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input logic a1, input logic a2, input logic [N-1:0] v);
        logic [2:0] exp;
        exp = model(a1, a2, v);
        checks++;
        if ({f, o1, o2} !== exp) begin
            errors++;
            $display("FAIL %s c1=%b c2=%b x=%b actual f/o1/o2=%b%b%b expected=%b",
                     req, a1, a2, v, f, o1, o2, exp);
        end
    endtask

    initial begin
        logic a1, a2;
        logic [N-1:0] v;
        logic fa;
        void'($urandom(32'd4217));

        // first state: all inputs low, true-form literals
        drive(0, 0, '0);
        check_out("R2", 0, 0, '0);

        // R1: every input combination in normal operation, both constant values
        for (int cc = 0; cc < 2; cc++) begin
            for (int i = 0; i < (1 << N); i++) begin
                drive(1, cc[0], N'(i));
                check_out("R1", 1, cc[0], N'(i));
            end
        end

        // R2: true-form function, every input combination
        for (int i = 0; i < (1 << N); i++) begin
            drive(0, i[0], N'(i));
            check_out("R2", 0, i[0], N'(i));
        end

        // R3: inverting c2 inverts f; R4/R5 judged on the same vectors
        for (int i = 0; i < 20; i++) begin
            v  = N'($urandom);
            a1 = 1'($urandom);
            drive(a1, 0, v);
            fa = f;
            drive(a1, 1, v);
            checks++;
            if (f !== ~fa) begin
                errors++;
                $display("FAIL R3 c1=%b x=%b actual f=%b expected=%b", a1, v, f, ~fa);
            end
            check_out("R4 R5", a1, 1, v);
        end

        // random vectors flipping both controls together
        for (int i = 0; i < 40; i++) begin
            v  = N'($urandom);
            a1 = 1'($urandom);
            a2 = 1'($urandom);
            drive(a1, a2, v);
            check_out("R1 R4 R5", a1, a2, v);
        end

        // R6: the test sequence itself
        for (int k = 0; k < NV; k++) begin
            test_vec(k, a1, a2, v);
            drive(a1, a2, v);
            check_out("R6", a1, a2, v);
        end

        // R7: each single stuck-at on x bits (0..N-1), c1 (N) and c2 (N+1)
        for (int tgt = 0; tgt < N + 2; tgt++) begin
            for (int sv = 0; sv < 2; sv++) begin
                logic det;
                det = 1'b0;
                for (int k = 0; k < NV; k++) begin
                    logic b1, b2;
                    logic [N-1:0] bv;
                    test_vec(k, a1, a2, v);
                    b1 = a1; b2 = a2; bv = v;
                    if (tgt < N) bv[tgt] = sv[0];
                    else if (tgt == N) b1 = sv[0];
                    else b2 = sv[0];
                    drive(b1, b2, bv);
                    if ({f, o1, o2} !== model(a1, a2, v)) det = 1'b1;
                end
                checks++;
                if (!det) begin
                    errors++;
                    $display("FAIL R7 target=%0d stuck=%0d actual detected=0 expected=1", tgt, sv);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule